// File: doc/BRIEF.md
# Port-Sizing External Memory Bus Controller

This block sits between an internal single-transfer request port and a narrow external asynchronous memory bus. An internal read or write of 8, 16 or 32 bits goes to one of several chip-select regions. Each region is chosen by a base address, an ignore mask and an enable bit, and each has its own external port width. When the access is wider than the selected port, the block splits it into consecutive external beats. The lowest address goes first, and the beat address steps by the port width.

Every beat runs through a start cycle, an address cycle, a data cycle and a terminating cycle. Optional setup, wait and hold cycles stretch these phases. The termination cycle closes the whole transfer, so it appears only on the last beat. Every earlier beat jumps from its data cycle straight to the start cycle of the next beat. Completion is generated internally (auto-acknowledge), with no external acknowledge pin. An address that hits no enabled region is answered at once with an error flag and produces no bus activity.

Top module: `memport_ctrl`

## Requirements
- R1: While and after synchronous reset (rst_n low), the block is idle: req_ready=1, bus_start=0, bus_cs=0, resp_valid=0, resp_err=0.
- R2: Size codes, used both for req_size and for each region's port code: 0=8 bits, 1=16 bits, 2=32 bits, 3 treated as 32 bits. An access is split into max(1, access bytes / port bytes) beats in increasing address order. Beat k uses address req_addr + k·(port bytes). Its bus_wdata is bits [k·P+W-1 : k·P] of req_wdata, where P is the port width in bits and W = min(access width, port width), right-justified and zero-extended. bus_we stays constant for the whole transaction.
- R3: With zero setup, wait and hold, a one-beat access takes 4 clocks: start, address, data, terminate. Back-to-back requests give bus_start pulses exactly 4 clocks apart.
- R4: Every non-final beat omits the terminating cycle and lasts 3 clocks with zero timing. A 32-bit access to a 16-bit port therefore spans 7 clocks, with its two start pulses 3 clocks apart.
- R5: The region's setup count adds that many clocks between the start cycle and the address cycle of every beat. Its wait count adds that many clocks between the address cycle and the data cycle of every beat.
- R6: Hold cycles follow the terminating cycle of the final beat only. Reads use the read-hold count and writes use the write-hold count.
- R7: A region matches when its enable bit is 1 and ((req_addr XOR base) AND NOT mask) is zero; mask bits set to 1 are ignored. When several regions match, the lowest index wins.
- R8: A request that matches no region gets a one-clock response with resp_valid=1 and resp_err=1 in the clock after acceptance. It produces no bus_start and no bus_cs.
- R9: bus_start is high for exactly one clock, the start cycle of each beat. bus_cs is one-hot on the selected region. It is high from the first address cycle through the last clock of the transaction, without a gap between beats.
- R10: For reads, bus_rdata is sampled on the clock edge that ends each data cycle and is placed in the lane given in R2. resp_rdata carries the assembled zero-extended value while resp_valid is high.
- R11: req_ready is high only when idle or in the final clock of a transaction, so a new request can follow without a gap. resp_valid is high for exactly that final clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | NCS*AW | Per-region base address, region i at [i*AW +: AW] |
| cfg_mask | input | NCS*AW | Per-region ignore mask (1 = address bit not compared) |
| cfg_valid | input | NCS | Per-region enable |
| cfg_port | input | NCS*2 | Per-region port width code |
| cfg_setup | input | NCS*SW | Per-region setup clocks |
| cfg_wait | input | NCS*WW | Per-region wait clocks |
| cfg_rdhold | input | NCS*HW | Per-region read hold clocks |
| cfg_wrhold | input | NCS*HW | Per-region write hold clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this clock when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Right-justified write data |
| resp_valid | output | 1 | Transaction completes this clock |
| resp_err | output | 1 | No region matched |
| resp_rdata | output | DW | Assembled read data |
| bus_start | output | 1 | Transfer start strobe, one per beat |
| bus_cs | output | NCS | Region select, active high |
| bus_we | output | 1 | External write direction |
| bus_addr | output | AW | External beat address |
| bus_wdata | output | DW | External write lane, right-justified |
| bus_rdata | input | DW | External read data, right-justified |

## Verification
The stimulus covers narrow, matching and wide accesses on a 16-bit region, where a wrong split shows up as a 3-clock versus 4-clock difference. It adds four-beat and two-beat reads and writes on an 8-bit region whose nonzero setup, wait and holds show whether the stretching lands on every beat or only on the last one. A single-beat access on a reconfigured 32-bit region, with size code 3, checks the width clamp. Unmatched, disabled and overlapping regions are tried separately, to tell the error response apart from the lowest-index priority. The read data returned from the external side depends on the beat address, so a wrong lane order or address step yields a different assembled word.

// File: rtl/memport_pkg.sv
// Shared types for the port-sizing memory bus controller.
// Assumes size codes are two bits with code 3 meaning the widest width.
package memport_pkg;

    // Bus phase of the current beat.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_SETUP,
        ST_ADDR,
        ST_WAIT,
        ST_DATA,
        ST_TERM,
        ST_HOLD,
        ST_FAULT
    } phase_t;

    // Map a size code to log2 of its byte count, clamping code 3 to 32 bits.
    function automatic logic [1:0] clamp_log2(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/memport_decode.sv
// Region decoder: compares the request address against every region's base
// under its ignore mask and picks the lowest-index enabled hit.
// Assumes the flat vectors hold region i at bit offset i*AW.
module memport_decode #(
    parameter int AW   = 32,
    parameter int NCS  = 2,
    parameter int SELW = 1
) (
    input  logic [AW-1:0]     addr,
    input  logic [NCS*AW-1:0] base_flat,
    input  logic [NCS*AW-1:0] mask_flat,
    input  logic [NCS-1:0]    valid,
    output logic              hit,
    output logic [SELW-1:0]   sel
);

    logic [NCS-1:0] match;

    // One comparator per region.
    generate
        for (genvar i = 0; i < NCS; i++) begin : g_cmp
            assign match[i] = valid[i] &&
                (((addr ^ base_flat[i*AW +: AW]) & ~mask_flat[i*AW +: AW]) == '0);
        end
    endgenerate

    // Priority pick: the lowest index is scanned last and so wins.
    always_comb begin
        hit = |match;
        sel = '0;
        for (int i = NCS - 1; i >= 0; i--) begin
            if (match[i]) sel = SELW'(i);
        end
    end

endmodule

// File: rtl/memport_lanes.sv
// Data lane steering: extracts the write lane for the current beat and merges
// a captured read lane into the accumulated result.
// Assumes the port width is never wider than DW and the data is right-justified.
module memport_lanes #(
    parameter int DW = 32,
    parameter int BW = 2
) (
    input  logic [1:0]    size_l,
    input  logic [1:0]    port_l,
    input  logic [BW-1:0] beat,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] rdata_in,
    output logic [DW-1:0] lane_wdata,
    output logic [DW-1:0] merged
);

    localparam int SHW = $clog2(DW) + 1;

    logic [1:0]     min_l;
    logic [SHW-1:0] lane_bits;
    logic [SHW-1:0] port_bits;
    logic [SHW-1:0] shift;
    logic [DW-1:0]  mask;

    // Lane width is the narrower of access and port; the offset is beat times port width.
    always_comb begin
        min_l      = (size_l < port_l) ? size_l : port_l;
        lane_bits  = SHW'(8) << min_l;
        port_bits  = SHW'(8) << port_l;
        shift      = port_bits * SHW'(beat);
        mask       = {DW{1'b1}} >> (SHW'(DW) - lane_bits);
        lane_wdata = (wdata >> shift) & mask;
        merged     = acc | ((rdata_in & mask) << shift);
    end

endmodule

// File: rtl/memport_seq.sv
// Beat sequencer: accepts a request, steps each beat through its bus phases,
// drops the terminating phase on all but the last beat, and signals completion.
// Assumes the region fields are valid in the accept cycle; they are latched there.
module memport_seq
    import memport_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int SELW = 1,
    parameter int SW   = 2,
    parameter int WW   = 6,
    parameter int HW   = 2,
    parameter int BW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_we,
    input  logic [1:0]      req_size,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic            hit,
    input  logic [SELW-1:0] sel,
    input  logic [1:0]      cfg_port,
    input  logic [SW-1:0]   cfg_setup,
    input  logic [WW-1:0]   cfg_wait,
    input  logic [HW-1:0]   cfg_rdhold,
    input  logic [HW-1:0]   cfg_wrhold,
    input  logic [DW-1:0]   merged,
    output logic            req_ready,
    output logic            resp_valid,
    output logic            resp_err,
    output logic [DW-1:0]   resp_rdata,
    output logic            bus_start,
    output logic            cs_en,
    output logic [SELW-1:0] cs_idx,
    output logic            bus_we,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   wdata_q,
    output logic [1:0]      size_q,
    output logic [1:0]      port_q,
    output logic [BW-1:0]   beat
);

    localparam int CW = (SW > WW) ? ((SW > HW) ? SW : HW) : ((WW > HW) ? WW : HW);

    phase_t          state;
    logic [CW-1:0]   cnt;
    logic [BW-1:0]   last_q;
    logic            we_q;
    logic            cs_hold;
    logic [SW-1:0]   setup_q;
    logic [WW-1:0]   wait_q;
    logic [HW-1:0]   hold_q;
    logic [DW-1:0]   acc;
    logic            last_cyc;
    logic            take;
    logic [1:0]      size_in;
    logic [1:0]      port_in;

    // Completion, handshake and bus strobes decoded from the phase.
    always_comb begin
        last_cyc   = ((state == ST_TERM) && (hold_q == '0)) ||
                     ((state == ST_HOLD) && (cnt == '0)) ||
                     (state == ST_FAULT);
        req_ready  = (state == ST_IDLE) || last_cyc;
        take       = req_valid && req_ready;
        resp_valid = last_cyc;
        resp_err   = (state == ST_FAULT);
        bus_start  = (state == ST_START);
        cs_en      = (state == ST_ADDR) || cs_hold;
        bus_we     = we_q && (state != ST_IDLE) && (state != ST_FAULT);
        size_in    = clamp_log2(req_size);
        port_in    = clamp_log2(cfg_port);
        resp_rdata = acc;
    end

    // Phase machine with per-beat counters and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            beat     <= '0;
            last_q   <= '0;
            we_q     <= 1'b0;
            cs_hold  <= 1'b0;
            cs_idx   <= '0;
            setup_q  <= '0;
            wait_q   <= '0;
            hold_q   <= '0;
            size_q   <= '0;
            port_q   <= '0;
            bus_addr <= '0;
            wdata_q  <= '0;
            acc      <= '0;
        end else begin
            case (state)
                ST_IDLE: ;
                ST_START: begin
                    if (setup_q != '0) begin
                        state <= ST_SETUP;
                        cnt   <= CW'(setup_q) - CW'(1);
                    end else begin
                        state <= ST_ADDR;
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) state <= ST_ADDR;
                    else           cnt   <= cnt - CW'(1);
                end
                ST_ADDR: begin
                    cs_hold <= 1'b1;
                    if (wait_q != '0) begin
                        state <= ST_WAIT;
                        cnt   <= CW'(wait_q) - CW'(1);
                    end else begin
                        state <= ST_DATA;
                    end
                end
                ST_WAIT: begin
                    if (cnt == '0) state <= ST_DATA;
                    else           cnt   <= cnt - CW'(1);
                end
                ST_DATA: begin
                    if (!we_q) acc <= merged;
                    if (beat == last_q) begin
                        state <= ST_TERM;
                    end else begin
                        beat     <= beat + BW'(1);
                        bus_addr <= bus_addr + (AW'(1) << port_q);
                        state    <= ST_START;
                    end
                end
                ST_TERM: begin
                    if (hold_q != '0) begin
                        state <= ST_HOLD;
                        cnt   <= CW'(hold_q) - CW'(1);
                    end
                end
                ST_HOLD: begin
                    if (cnt != '0) cnt <= cnt - CW'(1);
                end
                ST_FAULT: ;
                default: state <= ST_IDLE;
            endcase

            if (last_cyc) begin
                state   <= ST_IDLE;
                cs_hold <= 1'b0;
            end

            if (take) begin
                state    <= hit ? ST_START : ST_FAULT;
                we_q     <= req_we;
                size_q   <= size_in;
                port_q   <= port_in;
                setup_q  <= cfg_setup;
                wait_q   <= cfg_wait;
                hold_q   <= req_we ? cfg_wrhold : cfg_rdhold;
                cs_idx   <= sel;
                bus_addr <= req_addr;
                wdata_q  <= req_wdata;
                beat     <= '0;
                acc      <= '0;
                last_q   <= (size_in > port_in) ? BW'((1 << (size_in - port_in)) - 1) : '0;
            end
        end
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !bus_start); // R9
    AST_DATA_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> cs_en); // R9
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(bus_we)); // R2
    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !req_valid) |=> !resp_valid); // R11

endmodule

// File: rtl/memport_ctrl.sv
// Top of the port-sizing external memory bus controller: region decode,
// per-region field selection, beat sequencing and lane steering.
// Assumes DW is 32 so that port codes 0..2 all fit the data bus.
module memport_ctrl #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int NCS = 2,
    parameter int SW  = 2,
    parameter int WW  = 6,
    parameter int HW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCS*AW-1:0] cfg_base,
    input  logic [NCS*AW-1:0] cfg_mask,
    input  logic [NCS-1:0]    cfg_valid,
    input  logic [NCS*2-1:0]  cfg_port,
    input  logic [NCS*SW-1:0] cfg_setup,
    input  logic [NCS*WW-1:0] cfg_wait,
    input  logic [NCS*HW-1:0] cfg_rdhold,
    input  logic [NCS*HW-1:0] cfg_wrhold,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [1:0]        req_size,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [DW-1:0]     resp_rdata,
    output logic              bus_start,
    output logic [NCS-1:0]    bus_cs,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata
);

    localparam int SELW = (NCS > 1) ? $clog2(NCS) : 1;
    localparam int BW   = (DW > 8) ? $clog2(DW / 8) : 1;

    logic            hit;
    logic [SELW-1:0] sel;
    logic            cs_en;
    logic [SELW-1:0] cs_idx;
    logic [DW-1:0]   wdata_q;
    logic [1:0]      size_q;
    logic [1:0]      port_q;
    logic [BW-1:0]   beat;
    logic [DW-1:0]   merged;

    memport_decode #(.AW(AW), .NCS(NCS), .SELW(SELW)) u_decode (
        .addr      (req_addr),
        .base_flat (cfg_base),
        .mask_flat (cfg_mask),
        .valid     (cfg_valid),
        .hit       (hit),
        .sel       (sel)
    );

    memport_seq #(
        .AW(AW), .DW(DW), .SELW(SELW), .SW(SW), .WW(WW), .HW(HW), .BW(BW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_we     (req_we),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .hit        (hit),
        .sel        (sel),
        .cfg_port   (cfg_port[sel*2 +: 2]),
        .cfg_setup  (cfg_setup[sel*SW +: SW]),
        .cfg_wait   (cfg_wait[sel*WW +: WW]),
        .cfg_rdhold (cfg_rdhold[sel*HW +: HW]),
        .cfg_wrhold (cfg_wrhold[sel*HW +: HW]),
        .merged     (merged),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .resp_err   (resp_err),
        .resp_rdata (resp_rdata),
        .bus_start  (bus_start),
        .cs_en      (cs_en),
        .cs_idx     (cs_idx),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .wdata_q    (wdata_q),
        .size_q     (size_q),
        .port_q     (port_q),
        .beat       (beat)
    );

    memport_lanes #(.DW(DW), .BW(BW)) u_lanes (
        .size_l     (size_q),
        .port_l     (port_q),
        .beat       (beat),
        .wdata      (wdata_q),
        .acc        (resp_rdata),
        .rdata_in   (bus_rdata),
        .lane_wdata (bus_wdata),
        .merged     (merged)
    );

    // One-hot region select from the latched index.
    generate
        for (genvar i = 0; i < NCS; i++) begin : g_cs
            assign bus_cs[i] = cs_en && (cs_idx == SELW'(i));
        end
    endgenerate

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_cs)); // R9
    AST_CS_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_cs != '0) && !resp_valid) |=> (bus_cs == $past(bus_cs))); // R9
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> ((bus_cs == '0) && !bus_start)); // R8

endmodule

// File: tb/memport_ctrl_test.sv
// Cycle-level reference model of the controller, compared on every clock.
module memport_ctrl_test;

    localparam int AW = 32, DW = 32, NCS = 2, SW = 2, WW = 6, HW = 2;

    typedef struct {
        bit              start;
        bit [NCS-1:0]    cs;
        logic [31:0]     addr;
        bit              we;
        logic [31:0]     wdata;
        bit              last;
        bit              err;
        logic [31:0]     rdata;
        int              tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0] base [NCS];
    logic [AW-1:0] msk  [NCS];
    logic [NCS-1:0] vld;
    logic [1:0] prt [NCS];
    logic [SW-1:0] stp [NCS];
    logic [WW-1:0] wt [NCS];
    logic [HW-1:0] rh [NCS];
    logic [HW-1:0] wh [NCS];

    logic req_valid = 1'b0, req_we = 1'b0;
    logic [1:0] req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, resp_valid, resp_err, bus_start, bus_we;
    logic [DW-1:0] resp_rdata, bus_wdata, bus_rdata;
    logic [NCS-1:0] bus_cs;
    logic [AW-1:0] bus_addr;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[7:0] + 8'd3, a[7:0] + 8'd2, a[7:0] + 8'd1, a[7:0]} ^ 32'h5A3C_96E1;
    endfunction

    assign bus_rdata = mem_word(bus_addr);

    memport_ctrl #(.AW(AW), .DW(DW), .NCS(NCS), .SW(SW), .WW(WW), .HW(HW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_base({base[1], base[0]}), .cfg_mask({msk[1], msk[0]}), .cfg_valid(vld),
        .cfg_port({prt[1], prt[0]}), .cfg_setup({stp[1], stp[0]}), .cfg_wait({wt[1], wt[0]}),
        .cfg_rdhold({rh[1], rh[0]}), .cfg_wrhold({wh[1], wh[0]}),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .bus_start(bus_start), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int total = 0, bad = 0, cyc = 0, last_resp = 0;
    bit done = 1'b0;
    exp_t q[$];
    int starts[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    // Expected cycles of one accepted request, built from the requirements.
    function automatic void build(input bit we, input logic [1:0] size, input logic [31:0] addr,
                                  input logic [31:0] wdata);
        exp_t r;
        int sel = -1;
        int sl, pl, pb, nb, mn, lb, hold;
        logic [31:0] m, rd;
        for (int i = NCS - 1; i >= 0; i--)
            if (vld[i] && (((addr ^ base[i]) & ~msk[i]) == 32'h0)) sel = i;   // R7
        r.start = 0; r.cs = '0; r.addr = addr; r.we = we; r.wdata = 0;
        r.last = 0; r.err = 0; r.rdata = 0; r.tag = 2;
        if (sel < 0) begin   // R8
            r.err = 1; r.last = 1; r.tag = 8;
            q.push_back(r);
            return;
        end
        sl = (size == 2'd3) ? 2 : int'(size);
        pl = (prt[sel] == 2'd3) ? 2 : int'(prt[sel]);
        pb = 1 << pl;
        nb = (sl > pl) ? (1 << (sl - pl)) : 1;
        mn = (sl < pl) ? sl : pl;
        lb = 8 << mn;
        m  = (lb == 32) ? 32'hFFFF_FFFF : ((32'h1 << lb) - 32'h1);
        hold = we ? int'(wh[sel]) : int'(rh[sel]);
        rd = 0;
        for (int k = 0; k < nb; k++) begin
            logic [NCS-1:0] on;
            on = NCS'(1) << sel;
            r.addr  = addr + 32'(k * pb);
            r.wdata = (wdata >> (k * pb * 8)) & m;
            r.start = 1; r.cs = (k == 0) ? '0 : on; r.tag = (k == 0) ? 3 : 4;
            q.push_back(r);
            r.start = 0; r.tag = 5;
            for (int s = 0; s < int'(stp[sel]); s++) q.push_back(r);
            r.cs = on; r.tag = 9;
            q.push_back(r);
            r.tag = 5;
            for (int s = 0; s < int'(wt[sel]); s++) q.push_back(r);
            r.tag = (k < nb - 1) ? 4 : 3;
            q.push_back(r);
            rd = rd | ((mem_word(r.addr) & m) << (k * pb * 8));
            if (k == nb - 1) begin
                r.tag = 3; q.push_back(r);
                r.tag = 6;
                for (int s = 0; s < hold; s++) q.push_back(r);
                q[q.size() - 1].last  = 1;
                q[q.size() - 1].rdata = we ? 32'h0 : rd;
            end
        end
    endfunction

    // Model advance: retire one expected cycle, accept a new request when ready.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
        end else begin
            bit rdy;
            cyc++;
            rdy = (q.size() == 0) || q[0].last;
            if (q.size() != 0) void'(q.pop_front());
            if (rdy && req_valid) build(req_we, req_size, req_addr, req_wdata);
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            exp_t e;
            bit busy;
            busy = (q.size() != 0);
            if (busy) e = q[0];
            else begin
                e.start = 0; e.cs = '0; e.last = 0; e.err = 0; e.tag = 11;
                e.addr = 0; e.we = 0; e.wdata = 0; e.rdata = 0;
            end
            if (bus_start) starts.push_back(cyc);
            if (resp_valid) last_resp = cyc;
            chk(bus_start == e.start, $sformatf("R%0d/R9 start", e.tag), 32'(bus_start), 32'(e.start));
            chk(bus_cs == e.cs, $sformatf("R%0d/R9 cs", e.tag), 32'(bus_cs), 32'(e.cs));
            chk(req_ready == (!busy || e.last), "R11 ready", 32'(req_ready), 32'(!busy || e.last));
            chk(resp_valid == (busy && e.last), "R11 resp_valid", 32'(resp_valid), 32'(busy && e.last));
            chk(resp_err == e.err, "R8 resp_err", 32'(resp_err), 32'(e.err));
            if (busy && !e.err) begin
                chk(bus_addr == e.addr, "R2 addr", bus_addr, e.addr);
                chk(bus_we == e.we, "R2 we", 32'(bus_we), 32'(e.we));
                if (e.we) chk(bus_wdata == e.wdata, "R2 wdata", bus_wdata, e.wdata);
            end
            if (busy && e.last) chk(resp_rdata == e.rdata, "R10 rdata", resp_rdata, e.rdata);
        end
    end

    task automatic send(input bit we, input logic [1:0] size, input logic [31:0] addr,
                        input logic [31:0] wdata);
        req_valid = 1'b1; req_we = we; req_size = size; req_addr = addr; req_wdata = wdata;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        req_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        base[0] = 32'h1800_0000; msk[0] = 32'h0007_FFFF; prt[0] = 2'd1;
        stp[0] = 0; wt[0] = 0; rh[0] = 0; wh[0] = 0;
        base[1] = 32'h2000_0000; msk[1] = 32'h0000_FFFF; prt[1] = 2'd0;
        stp[1] = 1; wt[1] = 2; rh[1] = 1; wh[1] = 2;
        vld = 2'b11;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
        chk(bus_start == 1'b0, "R1 start", 32'(bus_start), 32'd0);
        chk(bus_cs == '0, "R1 cs", 32'(bus_cs), 32'd0);
        chk(resp_valid == 1'b0 && resp_err == 1'b0, "R1 resp", 32'(resp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: single 16-bit write on a 16-bit port
        send(1, 2'd1, 32'h1800_0010, 32'h0000_BEEF); settle();

        // R3: back-to-back 16-bit writes, start pulses 4 apart
        starts.delete();
        send(1, 2'd1, 32'h1800_0100, 32'h1111_0001);
        send(1, 2'd1, 32'h1800_0102, 32'h2222_0002);
        send(1, 2'd1, 32'h1800_0104, 32'h3333_0003);
        settle();
        chk(starts.size() == 3, "R3 start count", 32'(starts.size()), 32'd3);
        if (starts.size() == 3) begin
            chk(starts[1] - starts[0] == 4, "R3 spacing", 32'(starts[1] - starts[0]), 32'd4);
            chk(starts[2] - starts[1] == 4, "R3 spacing", 32'(starts[2] - starts[1]), 32'd4);
        end

        // R4: 32-bit write on a 16-bit port spans 7 clocks, beats 3 apart
        starts.delete();
        send(1, 2'd2, 32'h1800_0020, 32'hCAFE_1234); settle();
        chk(starts.size() == 2, "R4 beats", 32'(starts.size()), 32'd2);
        if (starts.size() == 2) begin
            chk(starts[1] - starts[0] == 3, "R4 beat length", 32'(starts[1] - starts[0]), 32'd3);
            chk(last_resp - starts[0] + 1 == 7, "R4 total", 32'(last_resp - starts[0] + 1), 32'd7);
        end

        // R10: 32-bit read on a 16-bit port; R2: 8-bit write lane on a 16-bit port
        send(0, 2'd2, 32'h1800_0040, 32'h0); settle();
        send(1, 2'd0, 32'h1800_0051, 32'hFFFF_FFA5); settle();

        // R5 R6: 8-bit port with setup, wait and holds
        send(0, 2'd2, 32'h2000_0100, 32'h0); settle();
        send(1, 2'd2, 32'h2000_0200, 32'h8765_4321); settle();
        send(0, 2'd1, 32'h2000_0300, 32'h0); settle();

        // R8: unmatched request, followed straight away by a matched one
        send(0, 2'd2, 32'h3000_0000, 32'h0);
        send(1, 2'd1, 32'h1800_0060, 32'h0000_5A5A); settle();

        // R7: disabled region is not matched
        vld[1] = 1'b0;
        send(0, 2'd1, 32'h2000_0000, 32'h0); settle();

        // R2: 32-bit port, size code 3 clamps to 32, nonzero timing on a single beat
        prt[0] = 2'd2; stp[0] = 2; wt[0] = 1; rh[0] = 2; wh[0] = 1;
        send(0, 2'd2, 32'h1800_0080, 32'h0); settle();
        send(1, 2'd2, 32'h1800_0084, 32'hA1B2_C3D4); settle();
        send(0, 2'd3, 32'h1800_0088, 32'h0); settle();

        // R7: overlapping regions, lowest index wins
        vld[1] = 1'b1; base[1] = 32'h1800_0000; msk[1] = 32'h000F_FFFF;
        send(0, 2'd1, 32'h1800_0200, 32'h0); settle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule